// File: doc/BRIEF.md
# Multi-Stream Time-Slot Allocation Table

This block holds the slot allocation table of a multi-stream transport link. It has four entries, and each entry pairs a source stream ID with the number of time slots that stream occupies. Software fills a pending copy of the table through a small write port. It then issues an update command. The block moves the pending copy into the active copy, which the transport framer reads, only at an MTP-header boundary. The framer's header strobe is the block's only time base.

The command comes in two kinds. The plain update swaps the tables at the next header. The update with an allocation-change trigger first raises a trigger to the framer for a fixed run of headers, and then swaps. After a triggered swap, a keepout flag holds for a further fixed run of headers. The command field clears by itself once the swap has happened, so software can poll it for completion. A table whose slot counts add up to more than the link can carry is refused, and an error flag is raised instead.

Top module: `slot_alloc_table`

## Requirements
- R1: After reset, every active entry reads source 0 and 0 slots, and the command, the trigger, the keepout flag and the error flag are all 0.
- R2: A write to address k (0 to 3) while no command is pending stores the entry as data bits [5:0] = slot count and bits [9:6] = source ID.
- R3: A write to address 4 is a command, with the code taken from data bits [1:0]: 1 means update with trigger and 2 means update without trigger. Codes 0 and 3 leave the command field at 0.
- R4: With code 2 pending, the first header strobe sampled on a clock after the command write copies the whole pending table to the active table, and the command field reads 0 from the same cycle.
- R5: With code 1 pending, the first header strobe raises the trigger. The trigger stays high while the next 4 strobes arrive. On the 4th of them the tables swap, the trigger drops and the command field clears.
- R6: A triggered swap sets the keepout flag. The flag clears on the 16th header strobe after the swap. A swap with code 2 leaves the flag untouched.
- R7: Writes to pending entries, and further command writes, are ignored while a command is pending.
- R8: The active table changes only at a swap.
- R9: A command of code 1 or 2 whose pending slot counts sum to more than 63 is not accepted: the command field stays 0 and the error flag is set. The next accepted command clears the flag.
- R10: The swap copies every entry, so entries written as source 0 with 0 slots appear in the active table as zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Addresses 0 to 3 are entries, address 4 is the command |
| wr_data_i | input | 10 | Write data |
| mtp_hdr_i | input | 1 | One-cycle MTP header strobe from the framer |
| act_sid_o | output | 16 | Active source IDs, entry i at bits [4i+3:4i] |
| act_slots_o | output | 24 | Active slot counts, entry i at bits [6i+5:6i] |
| alloc_trig_o | output | 1 | Allocation-change trigger to the framer |
| cmd_o | output | 2 | Command field readback |
| keepout_o | output | 1 | Post-swap keepout flag |
| over_alloc_o | output | 1 | Over-allocation error flag |

## Verification
The bench builds the block with its default parameters: four entries, 6-bit slot counts, a limit of 63 slots, a 4-header trigger run and a 16-header keepout. With these values one write of 34 slots to a table already at 63 crosses the limit, so a sum of exactly 63 and a sum of 64 can both be tried in the same run. The 16-header keepout window can be walked strobe by strobe within a few hundred cycles. The bench also places header strobes in the same cycle as a command write and on back-to-back cycles, which shows where the swap moment falls.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  typedef enum logic [1:0] {
    CMD_IDLE   = 2'd0,
    CMD_TRIG   = 2'd1,
    CMD_NOTRIG = 2'd2
  } cmd_e;
endpackage

// File: rtl/slot_sum.sv
module slot_sum #(
  parameter int NUM_ENTRIES = 4,
  parameter int SLOT_W      = 6,
  localparam int SUM_W      = SLOT_W + $clog2(NUM_ENTRIES)
) (
  input  logic [NUM_ENTRIES*SLOT_W-1:0] slots_i,
  output logic [SUM_W-1:0]              sum_o
);
  logic [SUM_W-1:0] part [NUM_ENTRIES+1];
  assign part[0] = '0;
  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_acc
    assign part[g+1] = part[g] + SUM_W'(slots_i[g*SLOT_W +: SLOT_W]);
  end
  assign sum_o = part[NUM_ENTRIES];
endmodule

// File: rtl/alloc_ctrl.sv
module alloc_ctrl
  import slot_alloc_pkg::*;
#(
  parameter int TRIG_HDRS = 4,
  localparam int TCNT_W   = $clog2(TRIG_HDRS + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cmd_wr_i,
  input  logic [1:0] cmd_code_i,
  input  logic       over_i,
  input  logic       hdr_i,
  output logic [1:0] cmd_o,
  output logic       trig_o,
  output logic       commit_o,
  output logic       keep_start_o,
  output logic       err_o
);
  cmd_e              cmd_q;
  logic              trig_q, err_q;
  logic [TCNT_W-1:0] tcnt_q;
  logic              code_ok, accept, trig_last;

  assign code_ok   = (cmd_code_i == CMD_TRIG) || (cmd_code_i == CMD_NOTRIG);
  assign accept    = cmd_wr_i && (cmd_q == CMD_IDLE) && code_ok;
  assign trig_last = trig_q && (tcnt_q == TCNT_W'(TRIG_HDRS - 1));

  always_comb begin
    commit_o     = 1'b0;
    keep_start_o = 1'b0;
    if (hdr_i) begin
      if (cmd_q == CMD_NOTRIG) commit_o = 1'b1;
      else if (cmd_q == CMD_TRIG && trig_last) begin
        commit_o     = 1'b1;
        keep_start_o = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= CMD_IDLE;
      trig_q <= 1'b0;
      err_q  <= 1'b0;
      tcnt_q <= '0;
    end else begin
      if (accept) begin
        if (over_i) err_q <= 1'b1;
        else begin
          err_q <= 1'b0;
          cmd_q <= cmd_e'(cmd_code_i);
        end
      end
      if (commit_o) begin
        cmd_q  <= CMD_IDLE;
        trig_q <= 1'b0;
        tcnt_q <= '0;
      end else if (hdr_i && cmd_q == CMD_TRIG) begin
        if (!trig_q) begin
          trig_q <= 1'b1;
          tcnt_q <= '0;
        end else begin
          tcnt_q <= tcnt_q + 1'b1;
        end
      end
    end
  end

  assign cmd_o  = cmd_q;
  assign trig_o = trig_q;
  assign err_o  = err_q;

  a_r3_cmd_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_o != 2'd3);
  a_r5_trig_only_code1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> cmd_o == CMD_TRIG);
  a_r4_commit_clears_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> cmd_o == CMD_IDLE);
  a_r9_err_blocks_cmd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> cmd_o == CMD_IDLE);
endmodule

// File: rtl/keepout_timer.sv
module keepout_timer #(
  parameter int HDRS     = 16,
  localparam int KCNT_W  = $clog2(HDRS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic hdr_i,
  output logic keepout_o
);
  logic              act_q;
  logic [KCNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      cnt_q <= '0;
    end else if (start_i) begin
      act_q <= 1'b1;
      cnt_q <= '0;
    end else if (act_q && hdr_i) begin
      if (cnt_q == KCNT_W'(HDRS - 1)) act_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign keepout_o = act_q;

  a_r6_keepout_from_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(keepout_o) |-> $past(start_i));
  a_r6_keepout_ends_on_hdr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(keepout_o) |-> $past(hdr_i));
endmodule

// File: rtl/slot_alloc_table.sv
module slot_alloc_table
  import slot_alloc_pkg::*;
#(
  parameter int NUM_ENTRIES  = 4,
  parameter int SID_W        = 4,
  parameter int SLOT_W       = 6,
  parameter int MAX_SLOTS    = 63,
  parameter int TRIG_HDRS    = 4,
  parameter int KEEPOUT_HDRS = 16,
  localparam int ADDR_W      = $clog2(NUM_ENTRIES + 1),
  localparam int DATA_W      = SID_W + SLOT_W,
  localparam int SUM_W       = SLOT_W + $clog2(NUM_ENTRIES)
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  input  logic                          mtp_hdr_i,
  output logic [NUM_ENTRIES*SID_W-1:0]  act_sid_o,
  output logic [NUM_ENTRIES*SLOT_W-1:0] act_slots_o,
  output logic                          alloc_trig_o,
  output logic [1:0]                    cmd_o,
  output logic                          keepout_o,
  output logic                          over_alloc_o
);
  logic [NUM_ENTRIES*SID_W-1:0]  pend_sid_q, act_sid_q;
  logic [NUM_ENTRIES*SLOT_W-1:0] pend_slots_q, act_slots_q;
  logic [SUM_W-1:0]              sum;
  logic                          over, cmd_wr, commit, keep_start, idle;

  assign idle   = (cmd_o == CMD_IDLE);
  assign cmd_wr = wr_en_i && (wr_addr_i == ADDR_W'(NUM_ENTRIES));
  assign over   = (sum > SUM_W'(MAX_SLOTS));

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pend_sid_q[e*SID_W +: SID_W]    <= '0;
        pend_slots_q[e*SLOT_W +: SLOT_W] <= '0;
      end else if (wr_en_i && idle && wr_addr_i == ADDR_W'(e)) begin
        pend_sid_q[e*SID_W +: SID_W]    <= wr_data_i[SLOT_W +: SID_W];
        pend_slots_q[e*SLOT_W +: SLOT_W] <= wr_data_i[SLOT_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_sid_q   <= '0;
      act_slots_q <= '0;
    end else if (commit) begin
      act_sid_q   <= pend_sid_q;
      act_slots_q <= pend_slots_q;
    end
  end

  slot_sum #(.NUM_ENTRIES(NUM_ENTRIES), .SLOT_W(SLOT_W)) u_sum (
    .slots_i (pend_slots_q),
    .sum_o   (sum)
  );

  alloc_ctrl #(.TRIG_HDRS(TRIG_HDRS)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cmd_wr_i     (cmd_wr),
    .cmd_code_i   (wr_data_i[1:0]),
    .over_i       (over),
    .hdr_i        (mtp_hdr_i),
    .cmd_o        (cmd_o),
    .trig_o       (alloc_trig_o),
    .commit_o     (commit),
    .keep_start_o (keep_start),
    .err_o        (over_alloc_o)
  );

  keepout_timer #(.HDRS(KEEPOUT_HDRS)) u_keep (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (keep_start),
    .hdr_i     (mtp_hdr_i),
    .keepout_o (keepout_o)
  );

  assign act_sid_o   = act_sid_q;
  assign act_slots_o = act_slots_q;

  a_r8_active_only_on_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit |=> $stable({act_sid_q, act_slots_q}));
  a_r7_pending_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !idle |=> $stable({pend_sid_q, pend_slots_q}));
endmodule

// File: tb/slot_alloc_table_test.sv
module slot_alloc_table_test;
  localparam int N = 4, SW = 4, LW = 6;

  logic clk = 0, rst_ni = 0;
  logic wr_en = 0, hdr = 0;
  logic [2:0] wr_addr = 0;
  logic [9:0] wr_data = 0;
  logic [N*SW-1:0] act_sid;
  logic [N*LW-1:0] act_slots;
  logic trig, keepout, err;
  logic [1:0] cmd;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  slot_alloc_table uut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .mtp_hdr_i(hdr), .act_sid_o(act_sid),
    .act_slots_o(act_slots), .alloc_trig_o(trig), .cmd_o(cmd),
    .keepout_o(keepout), .over_alloc_o(err)
  );

  // behavioural reference
  int p_sid[N], p_sl[N], a_sid[N], a_sl[N];
  int m_cmd, m_trig, m_tcnt, m_ko, m_kcnt, m_err;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (p_sid[i]) begin p_sid[i] = 0; p_sl[i] = 0; a_sid[i] = 0; a_sl[i] = 0; end
      m_cmd = 0; m_trig = 0; m_tcnt = 0; m_ko = 0; m_kcnt = 0; m_err = 0;
    end else begin
      int old_cmd, sum, code;
      bit swap, kstart;
      old_cmd = m_cmd; swap = 0; kstart = 0;
      if (m_cmd != 0 && hdr) begin
        if (m_cmd == 2) swap = 1;
        else if (m_trig == 0) begin m_trig = 1; m_tcnt = 0; end
        else if (m_tcnt == 3) begin swap = 1; kstart = 1; m_trig = 0; end
        else m_tcnt++;
      end
      if (kstart) begin m_ko = 1; m_kcnt = 0; end
      else if (m_ko == 1 && hdr) begin
        if (m_kcnt == 15) m_ko = 0; else m_kcnt++;
      end
      if (swap) begin
        foreach (a_sid[i]) begin a_sid[i] = p_sid[i]; a_sl[i] = p_sl[i]; end
        m_cmd = 0;
      end
      if (wr_en && old_cmd == 0) begin
        if (wr_addr < 3'(N)) begin
          p_sid[wr_addr] = int'(wr_data[9:6]);
          p_sl[wr_addr]  = int'(wr_data[5:0]);
        end else if (wr_addr == 3'(N)) begin
          code = int'(wr_data[1:0]);
          if (code == 1 || code == 2) begin
            sum = 0;
            foreach (p_sl[i]) sum += p_sl[i];
            if (sum > 63) m_err = 1;
            else begin m_err = 0; m_cmd = code; end
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      logic [N*SW-1:0] es; logic [N*LW-1:0] el;
      for (int i = 0; i < N; i++) begin
        es[i*SW +: SW] = SW'(a_sid[i]);
        el[i*LW +: LW] = LW'(a_sl[i]);
      end
      chk("R8 active sid", int'(act_sid), int'(es));
      chk("R8 active slots", int'(act_slots), int'(el));
      chk("R4 cmd", int'(cmd), m_cmd);
      chk("R5 trig", int'(trig), m_trig);
      chk("R6 keepout", int'(keepout), m_ko);
      chk("R9 err", int'(err), m_err);
    end
  end

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
    wr_en = 0; hdr = 0;
  endtask

  task automatic wr(int a, int d, bit h = 0);
    @(negedge clk);
    wr_en = 1; wr_addr = 3'(a); wr_data = 10'(d); hdr = h;
    @(negedge clk);
    wr_en = 0; hdr = 0;
  endtask

  task automatic ent(int a, int sid, int sl);
    wr(a, (sid << 6) | sl);
  endtask

  task automatic pulse();
    @(negedge clk); hdr = 1;
    @(negedge clk); hdr = 0;
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        done = 1;
      end
      begin
        cyc(3);
        rst_ni = 1;
        cyc(1);
        chk("R1 reset sid", int'(act_sid), 0);
        chk("R1 reset slots", int'(act_slots), 0);
        chk("R1 reset flags", int'({cmd, trig, keepout, err}), 0);

        // sum exactly 63, one unused entry
        ent(0, 1, 10); ent(1, 2, 20); ent(2, 0, 0); ent(3, 3, 33);
        wr(4, 2, 1);  // header in the same cycle as the command
        chk("R4 same-cycle header no swap", int'(act_slots), 0);
        chk("R3 code 2 accepted", int'(cmd), 2);
        ent(0, 9, 1);  // ignored
        wr(4, 1);      // ignored
        chk("R7 cmd unchanged", int'(cmd), 2);
        pulse();
        chk("R2 entry0 sid", int'(act_sid[3:0]), 1);
        chk("R2 entry0 slots", int'(act_slots[5:0]), 10);
        chk("R7 ignored write", int'(act_slots[5:0]), 10);
        chk("R10 unused entry zero", int'({act_sid[11:8], act_slots[17:12]}), 0);
        chk("R2 entry3 slots", int'(act_slots[23:18]), 33);
        chk("R6 no keepout for code 2", int'(keepout), 0);

        wr(4, 3); chk("R3 code 3 ignored", int'(cmd), 0);
        wr(4, 0); chk("R3 code 0 ignored", int'(cmd), 0);

        // over-allocation: 64
        ent(3, 3, 34);
        wr(4, 1);
        chk("R9 err set", int'(err), 1);
        chk("R9 cmd refused", int'(cmd), 0);
        pulse();
        chk("R8 unchanged after refused", int'(act_slots[23:18]), 33);
        ent(3, 5, 30);
        wr(4, 1);
        chk("R9 err cleared", int'(err), 0);

        // triggered update
        pulse();
        chk("R5 trig raised", int'(trig), 1);
        for (int k = 0; k < 3; k++) begin pulse(); cyc(2); end
        chk("R5 trig held", int'(trig), 1);
        chk("R8 not yet swapped", int'(act_sid[15:12]), 3);
        pulse();
        chk("R5 swapped", int'(act_sid[15:12]), 5);
        chk("R5 trig dropped", int'(trig), 0);
        chk("R6 keepout set", int'(keepout), 1);
        for (int k = 0; k < 15; k++) pulse();
        chk("R6 keepout held 15", int'(keepout), 1);
        pulse();
        chk("R6 keepout cleared", int'(keepout), 0);

        // back-to-back headers with code 1
        ent(1, 7, 5);
        wr(4, 1);
        @(negedge clk); hdr = 1;
        repeat (6) @(negedge clk);
        hdr = 0;
        cyc(2);
        chk("R5 back-to-back swap", int'(act_sid[7:4]), 7);
        chk("R6 keepout after burst", int'(keepout), 1);
        cyc(5);
        done = 1;
      end
    join_any
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule